// File: doc/BRIEF.md
# Serial Limit Compare Unit

This block grades a group of measured delay counts against test limits using one bit-serial arithmetic stage. Each measurement slice contributes a rise count and a fall count. All of these counts sit in one circular shift register. A second, smaller circular register holds two group-wide counts, one for rise and one for fall. That group pair carries either the group average or the group maximum; which of the two it holds depends on how the counts were generated. The counts are loaded in parallel. During a compare pass the counts rotate least significant bit first. At the same time, one signed limit per count arrives serially on a single test-data bit input.

In each pass the serial stage forms one value per count and compares it with the limit. The value is either the count itself, or the difference between a chosen partner count and the count. The possible partners are the same slice's rise count, the next slice's count of the same kind, slice 0 (the reference pin), or the group count of the same kind. A slice passes only when both of its items pass. The verdict bits, one per slice plus one for each group count, are then read out serially. Comparing against the group average gives an on-chip, per-device adaptive limit. Comparing against the group maximum gives a skew check.

Top module: `slc_limit_cmp`

## Requirements
- R1: While reset is low, and after it, `busy`, `done` and `res_bit` are 0 and every verdict bit is 0.
- R2: `ld` while idle captures `rise_cnt`, `fall_cnt`, `grp_rise` and `grp_fall`. Slice s uses bits [s*CW +: CW]. When `ld` and `start` are accepted in the same cycle, that pass works on the newly loaded counts. `ld` while `busy` has no effect.
- R3: `start` while idle raises `busy` on the next cycle. `busy` stays high for items*(CW+1) cycles, where items is 2*NSLICE for a slice pass and 2 for a group pass. One limit bit is taken on each busy cycle. `done` pulses for one cycle as `busy` falls. `start` while busy is ignored.
- R4: Each limit is CW+1 bits of two's complement, sent LSB first. Items come in the order slice0 rise, slice0 fall, slice1 rise, and so on. When `upper`=0 an item passes if value >= limit. When `upper`=1 it passes if value <= limit. A slice verdict is 1 only if both its items pass.
- R5: Mode 0 (direct): the value is the count itself. Codes 5 to 7 behave the same way.
- R6: Mode 1 (rise-fall): the rise item always passes. The fall item's value is the slice's rise count minus its fall count.
- R7: Mode 2 (neighbour): the value is the same-kind count of slice s+1 minus the own count. The last slice wraps to slice 0.
- R8: Mode 3 (reference): the value is the same-kind count of slice 0 minus the own count.
- R9: Mode 4 (group): the value is the same-kind group count (average or maximum) minus the own count.
- R10: With `grp_sel`=1 the pass compares the group rise count and then the group fall count directly. It writes only the two group verdicts and leaves the slice verdicts unchanged.
- R11: An accepted start clears to 0 the verdict bits that the pass will write, and only those.
- R12: `res_bit` shows the head of the verdict chain. The chain order is slice 0 up to slice NSLICE-1, then group rise, then group fall. `res_shift` while idle advances the chain and fills it with 0. `res_shift` is ignored while busy and in the cycle a start is accepted.
- R13: A pass leaves the stored counts unchanged, so a repeated pass gives the same verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld | input | 1 | Parallel count load strobe |
| rise_cnt | input | NSLICE*CW | Rise counts of all slices |
| fall_cnt | input | NSLICE*CW | Fall counts of all slices |
| grp_rise | input | CW | Group rise count (average or maximum) |
| grp_fall | input | CW | Group fall count (average or maximum) |
| start | input | 1 | Begin a compare pass |
| mode | input | 3 | Difference kind for a slice pass |
| upper | input | 1 | 1: limits are upper bounds, 0: lower bounds |
| grp_sel | input | 1 | 1: pass over the group counts |
| lim_bit | input | 1 | Serial limit bit, LSB first |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| res_shift | input | 1 | Advance the verdict chain |
| res_bit | output | 1 | Head of the verdict chain |

## Verification
Three events can land on one clock edge: a count load, a pass start and a verdict shift. Collisions between them are provoked on purpose. A load is issued together with a start, and the verdicts must then reflect the new counts. A start, a load with inverted counts and a shift request are all pulsed in the middle of a pass. That pass must still end on time and produce verdicts from the old counts. A second pass with the same limits must reproduce those verdicts.

// File: rtl/slc_pkg.sv
package slc_pkg;
   typedef enum logic [2:0] {
      MD_DIRECT    = 3'd0,
      MD_RISE_FALL = 3'd1,
      MD_NEIGHBOUR = 3'd2,
      MD_REFERENCE = 3'd3,
      MD_GROUP     = 3'd4
   } slc_mode_e;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_GT = 2'd1,
      REL_LT = 2'd2
   } slc_rel_e;
endpackage

// File: rtl/slc_count_ring.sv
// Circular register of all slice counts plus a copy of slice 0 for reference use.
module slc_count_ring #(
   parameter int NSLICE = 4,
   parameter int CW     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld,
   input  logic                     shift,
   input  logic                     kind,
   input  logic [$clog2(CW)-1:0]    bidx,
   input  logic [NSLICE*CW-1:0]     rise_flat,
   input  logic [NSLICE*CW-1:0]     fall_flat,
   output logic                     own_bit,
   output logic                     nb_bit,
   output logic                     rf_bit,
   output logic                     ref_bit
);
   localparam int L      = 2*NSLICE*CW;
   localparam int NB_TAP = (2*CW) % L;
   localparam int RF_TAP = L - CW;
   localparam int RW     = $clog2(2*CW);

   logic [L-1:0]    ring_q;
   logic [L-1:0]    ld_img;
   logic [2*CW-1:0] ref_q;
   logic [RW-1:0]   ridx;

   // interleave rise/fall so item k sits at k*CW
   generate
      for (genvar s = 0; s < NSLICE; s++) begin : g_img
         assign ld_img[2*s*CW +: CW]     = rise_flat[s*CW +: CW];
         assign ld_img[(2*s+1)*CW +: CW] = fall_flat[s*CW +: CW];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_q <= '0;
         ref_q  <= '0;
      end else if (ld) begin
         ring_q <= ld_img;
         ref_q  <= {fall_flat[CW-1:0], rise_flat[CW-1:0]};
      end else if (shift) begin
         ring_q <= {ring_q[0], ring_q[L-1:1]};
      end
   end

   assign ridx    = kind ? (RW'(CW) + RW'(bidx)) : RW'(bidx);
   assign own_bit = ring_q[0];
   assign nb_bit  = ring_q[NB_TAP];
   assign rf_bit  = ring_q[RF_TAP];
   assign ref_bit = ref_q[ridx];
endmodule

// File: rtl/slc_grp_ring.sv
// Two-entry circular register for the group-wide rise and fall counts.
module slc_grp_ring #(
   parameter int CW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld,
   input  logic                  shift,
   input  logic                  kind,
   input  logic [$clog2(CW)-1:0] bidx,
   input  logic [CW-1:0]         grp_rise,
   input  logic [CW-1:0]         grp_fall,
   output logic                  own_bit,
   output logic                  idx_bit
);
   localparam int RW = $clog2(2*CW);

   logic [2*CW-1:0] ring_q;
   logic [RW-1:0]   gidx;

   always_ff @(posedge clk) begin
      if (!rst_n)     ring_q <= '0;
      else if (ld)    ring_q <= {grp_fall, grp_rise};
      else if (shift) ring_q <= {ring_q[0], ring_q[2*CW-1:1]};
   end

   assign gidx    = kind ? (RW'(CW) + RW'(bidx)) : RW'(bidx);
   assign own_bit = ring_q[0];
   assign idx_bit = ring_q[gidx];
endmodule

// File: rtl/slc_serial_cmp.sv
// LSB-first subtract a-b with borrow, running signed compare against the limit.
module slc_serial_cmp
   import slc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic first,
   input  logic last,
   input  logic a_bit,
   input  logic b_bit,
   input  logic lim_bit,
   input  logic upper,
   output logic item_pass
);
   logic     br_q;
   slc_rel_e rel_q;
   logic     br_in, dif, br_nx;
   slc_rel_e rel_prev, rel_nx;

   always_comb begin
      br_in    = first ? 1'b0 : br_q;
      dif      = a_bit ^ b_bit ^ br_in;
      br_nx    = (~a_bit & b_bit) | (~(a_bit ^ b_bit) & br_in);
      rel_prev = first ? REL_EQ : rel_q;
      if (dif != lim_bit)
         // on the sign bit a set bit means smaller
         rel_nx = (dif ^ last) ? REL_GT : REL_LT;
      else
         rel_nx = rel_prev;
      item_pass = upper ? (rel_nx != REL_GT) : (rel_nx != REL_LT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         br_q  <= 1'b0;
         rel_q <= REL_EQ;
      end else if (en) begin
         br_q  <= br_nx;
         rel_q <= rel_nx;
      end
   end
endmodule

// File: rtl/slc_result.sv
// Verdict chain: slices first, then group rise, group fall; serial read-out.
module slc_result #(
   parameter int NSLICE = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_slc,
   input  logic                      clr_grp,
   input  logic                      shift,
   input  logic                      wr_slc,
   input  logic                      wr_grp,
   input  logic [$clog2(NSLICE)-1:0] slc_idx,
   input  logic                      grp_idx,
   input  logic                      val,
   output logic                      res_bit,
   output logic [NSLICE+1:0]         chain
);
   localparam int SW = $clog2(NSLICE);

   logic [NSLICE+1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (clr_slc) begin
         chain_q[NSLICE-1:0] <= '0;
      end else if (clr_grp) begin
         chain_q[NSLICE+1:NSLICE] <= '0;
      end else if (shift) begin
         chain_q <= {1'b0, chain_q[NSLICE+1:1]};
      end else begin
         if (wr_slc) begin
            for (int i = 0; i < NSLICE; i++)
               if (slc_idx == SW'(i)) chain_q[i] <= val;
         end
         if (wr_grp) begin
            if (grp_idx) chain_q[NSLICE+1] <= val;
            else         chain_q[NSLICE]   <= val;
         end
      end
   end

   assign res_bit = chain_q[0];
   assign chain   = chain_q;
endmodule

// File: rtl/slc_limit_cmp.sv
module slc_limit_cmp
   import slc_pkg::*;
#(
   parameter int NSLICE = 4,
   parameter int CW     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic [NSLICE*CW-1:0] rise_cnt,
   input  logic [NSLICE*CW-1:0] fall_cnt,
   input  logic [CW-1:0]        grp_rise,
   input  logic [CW-1:0]        grp_fall,
   input  logic                 start,
   input  logic [2:0]           mode,
   input  logic                 upper,
   input  logic                 grp_sel,
   input  logic                 lim_bit,
   output logic                 busy,
   output logic                 done,
   input  logic                 res_shift,
   output logic                 res_bit
);
   localparam int W     = CW + 1;
   localparam int NITEM = 2*NSLICE;
   localparam int IT_W  = $clog2(NITEM);
   localparam int J_W   = $clog2(W);
   localparam int BI_W  = $clog2(CW);

   generate
      if (NSLICE < 2) begin : g_bad_nslice
         $error("slc_limit_cmp: NSLICE must be at least 2");
      end
      if (CW < 2) begin : g_bad_cw
         $error("slc_limit_cmp: CW must be at least 2");
      end
   endgenerate

   logic            busy_q, done_q, grp_q, upper_q, rise_ok_q;
   slc_mode_e       mode_q;
   logic [IT_W-1:0] it_q;
   logic [J_W-1:0]  j_q;

   logic            start_ok, ld_ok, kind, msb, first, last_item;
   logic [BI_W-1:0] bidx;
   logic            s_own, s_nb, s_rf, s_ref, g_own, g_idx;
   logic            own, a_raw, b_raw, a_bit, b_bit;
   logic            item_pass, skip, pass_eff, wr_val;
   logic [NSLICE+1:0] ok_vec;

   assign start_ok  = start & ~busy_q;
   assign ld_ok     = ld & ~busy_q;
   assign kind      = it_q[0];
   assign msb       = (j_q == J_W'(CW));
   assign first     = (j_q == '0);
   assign bidx      = msb ? '0 : j_q[BI_W-1:0];
   assign last_item = grp_q ? (it_q == IT_W'(1)) : (it_q == IT_W'(NITEM-1));

   slc_count_ring #(.NSLICE(NSLICE), .CW(CW)) u_ring (
      .clk(clk), .rst_n(rst_n), .ld(ld_ok),
      .shift(busy_q & ~grp_q & ~msb), .kind(kind), .bidx(bidx),
      .rise_flat(rise_cnt), .fall_flat(fall_cnt),
      .own_bit(s_own), .nb_bit(s_nb), .rf_bit(s_rf), .ref_bit(s_ref));

   slc_grp_ring #(.CW(CW)) u_gring (
      .clk(clk), .rst_n(rst_n), .ld(ld_ok),
      .shift(busy_q & grp_q & ~msb), .kind(kind), .bidx(bidx),
      .grp_rise(grp_rise), .grp_fall(grp_fall),
      .own_bit(g_own), .idx_bit(g_idx));

   // operand selection: value = partner - own, or own alone
   always_comb begin
      own   = grp_q ? g_own : s_own;
      a_raw = own;
      b_raw = 1'b0;
      if (!grp_q) begin
         case (mode_q)
            MD_RISE_FALL: begin a_raw = s_rf;  b_raw = own; end
            MD_NEIGHBOUR: begin a_raw = s_nb;  b_raw = own; end
            MD_REFERENCE: begin a_raw = s_ref; b_raw = own; end
            MD_GROUP:     begin a_raw = g_idx; b_raw = own; end
            default:      begin a_raw = own;   b_raw = 1'b0; end
         endcase
      end
      a_bit = a_raw & ~msb;
      b_bit = b_raw & ~msb;
   end

   slc_serial_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .en(busy_q), .first(first), .last(msb),
      .a_bit(a_bit), .b_bit(b_bit), .lim_bit(lim_bit), .upper(upper_q),
      .item_pass(item_pass));

   assign skip     = ~grp_q & (mode_q == MD_RISE_FALL) & ~kind;
   assign pass_eff = skip | item_pass;
   assign wr_val   = grp_q ? item_pass : (rise_ok_q & pass_eff);

   slc_result #(.NSLICE(NSLICE)) u_res (
      .clk(clk), .rst_n(rst_n),
      .clr_slc(start_ok & ~grp_sel), .clr_grp(start_ok & grp_sel),
      .shift(res_shift & ~busy_q & ~start_ok),
      .wr_slc(busy_q & ~grp_q & msb & kind),
      .wr_grp(busy_q & grp_q & msb),
      .slc_idx(it_q[IT_W-1:1]), .grp_idx(kind), .val(wr_val),
      .res_bit(res_bit), .chain(ok_vec));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         grp_q     <= 1'b0;
         upper_q   <= 1'b0;
         rise_ok_q <= 1'b0;
         mode_q    <= MD_DIRECT;
         it_q      <= '0;
         j_q       <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_ok) begin
            busy_q  <= 1'b1;
            grp_q   <= grp_sel;
            upper_q <= upper;
            mode_q  <= slc_mode_e'(mode);
            it_q    <= '0;
            j_q     <= '0;
         end else if (busy_q) begin
            if (msb) begin
               j_q <= '0;
               if (!kind) rise_ok_q <= pass_eff;
               if (last_item) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  it_q   <= '0;
               end else begin
                  it_q <= it_q + 1'b1;
               end
            end else begin
               j_q <= j_q + 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/slc_chk.sv
module slc_chk #(
   parameter int NSLICE = 4,
   parameter int CW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              grp_sel,
   input logic              busy,
   input logic              done,
   input logic              res_shift,
   input logic [NSLICE+1:0] ok_vec
);
   logic        g_q;
   int unsigned cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g_q   <= 1'b0;
         cnt_q <= 0;
      end else if (start && !busy) begin
         g_q   <= grp_sel;
         cnt_q <= 0;
      end else if (busy) begin
         cnt_q <= cnt_q + 1;
      end
   end

   always @(negedge clk) begin
      if (!rst_n)
         p_reset_state_r1: assert (!busy && !done && ok_vec == '0);
   end

   p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_pass_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cnt_q == (g_q ? 2 : 2*NSLICE) * (CW+1)));

   p_slice_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !g_q) |-> (ok_vec[NSLICE-1:0] == '0));

   p_group_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && g_q) |-> (ok_vec[NSLICE+1:NSLICE] == '0));

   p_group_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !g_q) |=> $stable(ok_vec[NSLICE+1:NSLICE]));

   p_shift_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && res_shift && !start) |=> (ok_vec == ($past(ok_vec) >> 1)));
endmodule

bind slc_limit_cmp slc_chk #(.NSLICE(NSLICE), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .grp_sel(grp_sel),
   .busy(busy), .done(done), .res_shift(res_shift), .ok_vec(ok_vec));

// File: tb/sim_slc_limit_cmp.sv
`timescale 1ns/1ps
module sim_slc_limit_cmp;
   localparam int NS = 4;
   localparam int CW = 8;
   localparam int W  = CW + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ld = 1'b0;
   logic [NS*CW-1:0] rise_cnt = '0;
   logic [NS*CW-1:0] fall_cnt = '0;
   logic [CW-1:0]    grp_rise = '0;
   logic [CW-1:0]    grp_fall = '0;
   logic             start = 1'b0;
   logic [2:0]       mode = 3'd0;
   logic             upper = 1'b0;
   logic             grp_sel = 1'b0;
   logic             lim_bit = 1'b0;
   logic             busy, done, res_bit;
   logic             res_shift = 1'b0;

   int checks = 0;
   int errors = 0;
   int rs[NS];
   int fs[NS];
   int gr, gf;
   int lim[2*NS];
   int exp_chain[NS+2];

   always #4 clk = ~clk;

   slc_limit_cmp #(.NSLICE(NS), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .ld(ld), .rise_cnt(rise_cnt), .fall_cnt(fall_cnt),
      .grp_rise(grp_rise), .grp_fall(grp_fall), .start(start), .mode(mode),
      .upper(upper), .grp_sel(grp_sel), .lim_bit(lim_bit), .busy(busy),
      .done(done), .res_shift(res_shift), .res_bit(res_bit));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive_counts();
      for (int s = 0; s < NS; s++) begin
         rise_cnt[s*CW +: CW] = rs[s][CW-1:0];
         fall_cnt[s*CW +: CW] = fs[s][CW-1:0];
      end
      grp_rise = gr[CW-1:0];
      grp_fall = gf[CW-1:0];
   endtask

   function automatic int cnt(input int kind, input int s);
      return kind != 0 ? fs[s] : rs[s];
   endfunction

   // expected item verdict from the requirement text (R4..R10)
   function automatic int item_ok(input int m, input int up, input int g, input int k);
      int s, kind, own, v;
      s = k / 2; kind = k % 2; own = cnt(kind, s);
      if (g != 0) v = (k != 0) ? gf : gr;
      else begin
         case (m)
            1: begin if (kind == 0) return 1; v = rs[s] - fs[s]; end
            2: v = cnt(kind, (s+1) % NS) - own;
            3: v = cnt(kind, 0) - own;
            4: v = ((kind != 0) ? gf : gr) - own;
            default: v = own;
         endcase
      end
      return (up != 0) ? int'(v <= lim[k]) : int'(v >= lim[k]);
   endfunction

   task automatic load_counts();
      @(negedge clk);
      drive_counts();
      ld = 1'b1;
      @(negedge clk);
      ld = 1'b0;
   endtask

   task automatic run_pass(input int m, input int up, input int g, input int with_ld,
                           input int disturb, input int chk_clr);
      int n;
      n = (g != 0) ? 2 : 2*NS;
      @(negedge clk);
      mode = m[2:0]; upper = up[0]; grp_sel = g[0]; start = 1'b1;
      if (with_ld != 0) begin drive_counts(); ld = 1'b1; end
      @(negedge clk);
      start = 1'b0; ld = 1'b0;
      chk("R3 busy after start", int'(busy), 1);
      if (chk_clr != 0) chk("R11 verdict cleared at start", int'(res_bit), 0);
      for (int k = 0; k < n; k++) begin
         for (int b = 0; b < W; b++) begin
            logic [W-1:0] lv;
            lv = lim[k][W-1:0];
            lim_bit = lv[b];
            if (disturb != 0 && k == 3 && b == 2) begin
               start = 1'b1; ld = 1'b1; res_shift = 1'b1; rise_cnt = ~rise_cnt;
            end
            if (k == n-1 && b == W-1) chk("R3 busy on last limit bit", int'(busy), 1);
            @(negedge clk);
            start = 1'b0; ld = 1'b0; res_shift = 1'b0;
         end
      end
      chk("R3 done pulse", int'(done), 1);
      chk("R3 busy dropped", int'(busy), 0);
      @(negedge clk);
      chk("R3 done single cycle", int'(done), 0);
      if (g != 0) begin
         for (int k = 0; k < 2; k++) exp_chain[NS+k] = item_ok(m, up, 1, k);
      end else begin
         for (int s = 0; s < NS; s++)
            exp_chain[s] = item_ok(m, up, 0, 2*s) & item_ok(m, up, 0, 2*s+1);
      end
   endtask

   task automatic read_chain(input string req);
      for (int i = 0; i < NS+2; i++) begin
         chk(req, int'(res_bit), exp_chain[i]);
         res_shift = 1'b1;
         @(negedge clk);
         res_shift = 1'b0;
      end
      chk("R12 zero fill after read-out", int'(res_bit), 0);
      for (int i = 0; i < NS+2; i++) exp_chain[i] = 0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 done in reset", int'(done), 0);
      chk("R1 res_bit in reset", int'(res_bit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      for (int i = 0; i < NS+2; i++) exp_chain[i] = 0;
   endtask

   task automatic t_direct();
      rs = '{10, 20, 30, 40}; fs = '{15, 25, 35, 45}; gr = 25; gf = 30;
      load_counts();
      lim = '{10, 16, 21, 25, 30, 35, 41, 44};
      run_pass(0, 0, 0, 0, 0, 0);
      read_chain("R5 R4 direct lower");
      run_pass(0, 1, 0, 0, 0, 0);
      read_chain("R5 R4 direct upper");
      run_pass(6, 1, 0, 0, 0, 0);
      read_chain("R5 unused code acts direct");
   endtask

   task automatic t_rise_fall();
      rs = '{50, 20, 7, 100}; fs = '{40, 30, 7, 0};
      load_counts();
      lim = '{200, 10, 200, -9, 200, 0, 200, 101};
      run_pass(1, 0, 0, 0, 0, 0);
      read_chain("R6 rise minus fall lower");
      lim = '{-256, 9, -256, -10, -256, -1, -256, 100};
      run_pass(1, 1, 0, 0, 0, 0);
      read_chain("R6 rise minus fall upper");
   endtask

   task automatic t_neighbour();
      rs = '{10, 40, 25, 5}; fs = '{3, 3, 9, 1};
      load_counts();
      lim = '{30, 0, -15, 6, -21, -8, 5, 2};
      run_pass(2, 1, 0, 0, 0, 0);
      read_chain("R7 neighbour upper with wrap");
      run_pass(2, 0, 0, 0, 0, 0);
      read_chain("R7 neighbour lower with wrap");
   endtask

   task automatic t_reference();
      rs = '{100, 90, 120, 100}; fs = '{60, 61, 40, 59};
      load_counts();
      lim = '{0, 0, 10, -1, -20, 20, 0, 1};
      run_pass(3, 0, 0, 0, 0, 0);
      read_chain("R8 reference lower");
   endtask

   task automatic t_group_mode();
      rs = '{30, 12, 255, 0}; fs = '{20, 20, 0, 19}; gr = 30; gf = 20;
      load_counts();
      lim = '{0, 0, 18, 0, -225, 20, 30, 1};
      run_pass(4, 0, 0, 0, 0, 0);
      read_chain("R9 group count minus own");
   endtask

   task automatic t_group_pass();
      rs = '{5, 6, 7, 8}; fs = '{9, 10, 11, 12}; gr = 100; gf = 50;
      load_counts();
      lim = '{0, 0, 0, 0, 0, 0, 0, 0};
      run_pass(0, 0, 0, 0, 0, 0);
      lim[0] = 90; lim[1] = 60;
      run_pass(0, 0, 1, 0, 0, 0);
      read_chain("R10 group pass keeps slice verdicts");
      lim[0] = 100; lim[1] = 50;
      run_pass(0, 1, 1, 0, 0, 0);
      read_chain("R10 group upper bound equal");
   endtask

   task automatic t_clear();
      rs = '{40, 40, 40, 40}; fs = '{40, 40, 40, 40};
      load_counts();
      lim = '{0, 0, 0, 0, 0, 0, 0, 0};
      run_pass(0, 0, 0, 0, 0, 0);
      lim = '{0, 0, 0, 41, 0, 0, 0, 0};
      run_pass(0, 0, 0, 0, 0, 1);
      read_chain("R11 second pass results");
   endtask

   task automatic t_load_with_start();
      rs = '{1, 200, 3, 4}; fs = '{2, 2, 2, 2};
      lim = '{100, 0, 100, 0, 100, 0, 100, 0};
      run_pass(0, 0, 0, 1, 0, 0);
      read_chain("R2 load in start cycle used");
   endtask

   task automatic t_disturb();
      rs = '{17, 99, 3, 64}; fs = '{8, 120, 33, 64};
      load_counts();
      lim = '{17, 9, 98, 120, 4, 33, 64, 64};
      run_pass(0, 0, 0, 0, 1, 0);
      read_chain("R2 R3 R12 mid-pass load start shift ignored");
      run_pass(0, 0, 0, 0, 0, 0);
      read_chain("R13 repeated pass same verdicts");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_direct();
      t_rise_fall();
      t_neighbour();
      t_reference();
      t_group_mode();
      t_group_pass();
      t_clear();
      t_load_with_start();
      t_disturb();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule